// File: doc/BRIEF.md
# LIN Break and Frame Controller

This block is a byte-level serial controller for a LIN 2.1 node. It can act as a master or as a slave. The host places a byte in a transmit holding register, and the block sends it on a single TX line as an asynchronous character. When the node is a master, the host can ask for a break field and delimiter before the byte. Their lengths are set in bit times. This lets a master open a header with the break and then send the sync and identifier bytes as ordinary characters.

On the receive side, the RX line is synchronised and oversampled sixteen times per bit. Each bit is taken at mid-bit, counted from the falling edge of the start bit. A completed byte moves into a receive buffer that the host reads. Sticky flags report parity, framing and overrun errors, and a slave also reports a detected break. Transmit and receive run independently and at the same time. Both take their bit timing from one shared, programmable divider.

Top module: `lin_frame_ctrl`

## Requirements
- R1: After reset, txLine is 1, txReady is 1, rxValid is 0, and parityErr, frameErr, overrunErr and breakDet are all 0.
- R2: A transmitted character is a 0 start bit, then eight data bits with the least significant first, then an optional parity bit, then a 1 stop bit. Each bit lasts exactly 16*(baudDiv+1) clock cycles.
- R3: When parityEn is 1, a parity bit follows the data. With parityOdd = 0 it makes the count of ones in data plus parity even; with parityOdd = 1 it makes that count odd.
- R4: Transmit is double-buffered. txReady falls in the cycle after an accepted write (txWrite while txReady is 1). A second byte can be queued while the first one shifts out, and it starts right at the end of the first byte's stop bit.
- R5: In master mode (isMaster = 1), a write with txBrk = 1 first drives the line low for (13 + brkLen) bit times, then high for (1 + delimLen) bit times, then sends the byte. brkLen and delimLen are 2-bit fields.
- R6: In slave mode, txBrk is ignored: the byte is sent with no break, so the first low period is one start bit long.
- R7: A received character sets rxValid and presents the byte on rxData. A one-cycle rxRead pulse clears rxValid.
- R8: With parityEn = 1, a received parity bit that disagrees with the selected parity sets parityErr.
- R9: A received stop bit sampled as 0 sets frameErr. The byte is still delivered.
- R10: A byte that completes while rxValid is still 1 and not being read sets overrunErr. rxData keeps the older byte.
- R11: In slave mode, an RX line held low for at least 11 bit times sets breakDet. In master mode, the same stimulus leaves breakDet at 0.
- R12: A one-cycle errClear pulse returns all four error and break flags to 0.
- R13: Transmit and receive run at the same time without disturbing each other.
- R14: A low pulse on RX shorter than half a bit is rejected as a false start, and no byte is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| isMaster | input | 1 | 1 selects master mode, 0 selects slave mode |
| baudDiv | input | 16 | Divider value; bit time is 16*(baudDiv+1) cycles |
| brkLen | input | 2 | Break length select, 13 plus this value in bit times |
| delimLen | input | 2 | Delimiter length select, 1 plus this value in bit times |
| parityEn | input | 1 | Adds a parity bit to both directions |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| txWrite | input | 1 | Writes txData into the transmit holding register |
| txData | input | 8 | Byte to send |
| txBrk | input | 1 | Asks for a break and delimiter before this byte (master only) |
| txReady | output | 1 | The holding register is empty |
| txLine | output | 1 | Serial transmit line, idles high |
| rxLine | input | 1 | Serial receive line, asynchronous |
| rxRead | input | 1 | Pops the receive buffer |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | The receive buffer holds an unread byte |
| parityErr | output | 1 | Sticky parity error flag |
| frameErr | output | 1 | Sticky framing error flag |
| overrunErr | output | 1 | Sticky overrun flag |
| breakDet | output | 1 | Sticky break-detected flag (slave) |
| errClear | input | 1 | Clears the sticky flags |

## Verification
A transmission starts on the first divider tick after the write, and every later edge on txLine falls on a tick. Because of this, break, delimiter and bit lengths are exact multiples of 16*(baudDiv+1) cycles. The bench measures them as run lengths counted on falling clock edges, and it samples each data bit half a bit after the edge that opens the bit. Received bytes appear at the mid-stop sample, about 9.5 bit times (10.5 with parity) after the start edge plus two synchroniser cycles. The bench checks rxData and the flags only after it has finished driving the whole stop bit, so the result is already settled. Read and clear pulses are checked one cycle later.

// File: rtl/lin_pkg.sv
package lin_pkg;
  typedef struct packed {
    logic       done;
    logic [7:0] data;
    logic       parBad;
    logic       stopBad;
    logic       brk;
  } rxEvt_t;

  typedef enum logic [2:0] {
    TX_IDLE, TX_BREAK, TX_DELIM, TX_START, TX_DATA, TX_PAR, TX_STOP
  } txState_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rxState_t;
endpackage

// File: rtl/lin_baud_gen.sv
module lin_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] baudDiv,
  output logic             tick
);
  logic [DIV_W-1:0] divCnt;

  assign tick = (divCnt == baudDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= tick ? '0 : divCnt + 1'b1;
  end
endmodule

// File: rtl/lin_tx_unit.sv
module lin_tx_unit
  import lin_pkg::*;
#(
  parameter int OVS_W      = 4,
  parameter int LEN_W      = 2,
  parameter int BRK_BASE   = 13,
  parameter int DELIM_BASE = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             isMaster,
  input  logic [LEN_W-1:0] brkLen,
  input  logic [LEN_W-1:0] delimLen,
  input  logic             parityEn,
  input  logic             parityOdd,
  input  logic             txWrite,
  input  logic [7:0]       txData,
  input  logic             txBrk,
  output logic             txReady,
  output logic             txLine
);
  localparam int CNT_W = $clog2(BRK_BASE + (1 << LEN_W) + 1);
  localparam logic [OVS_W-1:0] SUB_LAST = '1;

  txState_t         txState;
  logic [OVS_W-1:0] sub;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0]       shiftQ, holdData;
  logic             holdFull, holdBrk, parBit;
  logic             bitEnd, launch;
  logic [CNT_W-1:0] brkLast, delimLast;

  assign brkLast   = CNT_W'(BRK_BASE - 1) + CNT_W'(brkLen);
  assign delimLast = CNT_W'(DELIM_BASE - 1) + CNT_W'(delimLen);
  assign bitEnd    = tick && (sub == SUB_LAST) && (txState != TX_IDLE);
  assign launch    = tick && holdFull &&
                     ((txState == TX_IDLE) || (txState == TX_STOP && sub == SUB_LAST));
  assign txReady   = !holdFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState  <= TX_IDLE;
      sub      <= '0;
      bitCnt   <= '0;
      shiftQ   <= '0;
      holdData <= '0;
      holdFull <= 1'b0;
      holdBrk  <= 1'b0;
      parBit   <= 1'b0;
      txLine   <= 1'b1;
    end else begin
      if (txWrite && !holdFull) begin
        holdData <= txData;
        holdBrk  <= txBrk;
        holdFull <= 1'b1;
      end
      if (launch) begin
        holdFull <= 1'b0;
        shiftQ   <= holdData;
        parBit   <= parityOdd ? ~^holdData : ^holdData;
        sub      <= '0;
        bitCnt   <= '0;
        txLine   <= 1'b0;
        txState  <= (holdBrk && isMaster) ? TX_BREAK : TX_START;
      end else if (bitEnd) begin
        sub <= '0;
        case (txState)
          TX_BREAK:
            if (bitCnt == brkLast) begin
              txState <= TX_DELIM; txLine <= 1'b1; bitCnt <= '0;
            end else bitCnt <= bitCnt + 1'b1;
          TX_DELIM:
            if (bitCnt == delimLast) begin
              txState <= TX_START; txLine <= 1'b0; bitCnt <= '0;
            end else bitCnt <= bitCnt + 1'b1;
          TX_START: begin
            txState <= TX_DATA;
            txLine  <= shiftQ[0];
            shiftQ  <= shiftQ >> 1;
            bitCnt  <= '0;
          end
          TX_DATA:
            if (bitCnt == CNT_W'(7)) begin
              if (parityEn) begin txState <= TX_PAR;  txLine <= parBit; end
              else          begin txState <= TX_STOP; txLine <= 1'b1;   end
            end else begin
              txLine <= shiftQ[0];
              shiftQ <= shiftQ >> 1;
              bitCnt <= bitCnt + 1'b1;
            end
          TX_PAR:  begin txState <= TX_STOP; txLine <= 1'b1; end
          default: txState <= TX_IDLE;
        endcase
      end else if (tick && txState != TX_IDLE) begin
        sub <= sub + 1'b1;
      end
    end
  end

  assert_hold_taken_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txWrite && txReady) |=> !txReady) else $error("holding register not taken");
  assert_break_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_BREAK) |-> (txLine == 1'b0)) else $error("break not dominant");
  assert_break_master_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_BREAK && $past(txState) != TX_BREAK) |-> $past(isMaster))
    else $error("break started in slave mode");
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_IDLE) |-> txLine) else $error("idle line not recessive");
endmodule

// File: rtl/lin_rx_sampler.sv
module lin_rx_sampler
  import lin_pkg::*;
#(
  parameter int OVS_W        = 4,
  parameter int BRK_DET_BITS = 11
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   tick,
  input  logic   rxLine,
  input  logic   parityEn,
  input  logic   parityOdd,
  output rxEvt_t evt
);
  localparam logic [OVS_W-1:0] SUB_MID = OVS_W'((1 << OVS_W) / 2 - 1);
  localparam int BRK_TICKS = BRK_DET_BITS * (1 << OVS_W);
  localparam int LOW_W     = $clog2(BRK_TICKS + 1);

  rxState_t         rxState;
  logic [1:0]       syncQ;
  logic             rxS, rxPrev, parRx;
  logic [OVS_W-1:0] sub;
  logic [2:0]       bitCnt;
  logic [7:0]       shiftQ;
  logic [LOW_W-1:0] lowCnt;

  assign rxS = syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      rxPrev  <= 1'b1;
      rxState <= RX_IDLE;
      sub     <= '0;
      bitCnt  <= '0;
      shiftQ  <= '0;
      parRx   <= 1'b0;
      lowCnt  <= '0;
      evt     <= '0;
    end else begin
      syncQ       <= {syncQ[0], rxLine};
      rxPrev      <= rxS;
      evt.done    <= 1'b0;
      evt.brk     <= 1'b0;
      if (rxS) lowCnt <= '0;
      else if (tick && lowCnt != LOW_W'(BRK_TICKS)) begin
        lowCnt <= lowCnt + 1'b1;
        if (lowCnt == LOW_W'(BRK_TICKS - 1)) evt.brk <= 1'b1;
      end
      if (rxState == RX_IDLE) begin
        if (rxPrev && !rxS) begin
          rxState <= RX_START;
          sub     <= '0;
        end
      end else if (tick) begin
        sub <= sub + 1'b1;
        if (sub == SUB_MID) begin
          case (rxState)
            RX_START:
              if (rxS) rxState <= RX_IDLE;
              else begin rxState <= RX_DATA; bitCnt <= '0; end
            RX_DATA: begin
              shiftQ <= {rxS, shiftQ[7:1]};
              if (bitCnt == 3'd7) rxState <= parityEn ? RX_PAR : RX_STOP;
              else bitCnt <= bitCnt + 1'b1;
            end
            RX_PAR: begin parRx <= rxS; rxState <= RX_STOP; end
            default: begin
              evt.done    <= 1'b1;
              evt.data    <= shiftQ;
              evt.stopBad <= !rxS;
              evt.parBad  <= parityEn && (parRx != (parityOdd ? ~^shiftQ : ^shiftQ));
              rxState     <= RX_IDLE;
            end
          endcase
        end
      end
    end
  end

  assert_break_while_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    evt.brk |-> ($past(rxS) == 1'b0)) else $error("break flagged on high line");
endmodule

// File: rtl/lin_rx_buffer.sv
module lin_rx_buffer
  import lin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rxEvt_t     evt,
  input  logic       isMaster,
  input  logic       rxRead,
  input  logic       errClear,
  output logic       rxValid,
  output logic [7:0] rxData,
  output logic       parityErr,
  output logic       frameErr,
  output logic       overrunErr,
  output logic       breakDet
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxValid    <= 1'b0;
      rxData     <= '0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
      breakDet   <= 1'b0;
    end else begin
      if (evt.done) begin
        if (!(rxValid && !rxRead)) begin
          rxData  <= evt.data;
          rxValid <= 1'b1;
        end
      end else if (rxRead) begin
        rxValid <= 1'b0;
      end
      parityErr  <= (parityErr  && !errClear) || (evt.done && evt.parBad);
      frameErr   <= (frameErr   && !errClear) || (evt.done && evt.stopBad);
      overrunErr <= (overrunErr && !errClear) || (evt.done && rxValid && !rxRead);
      breakDet   <= (breakDet   && !errClear) || (evt.brk && !isMaster);
    end
  end

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxRead && !evt.done) |=> !rxValid) else $error("read did not empty buffer");
  assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> $past(rxValid)) else $error("overrun without pending byte");
endmodule

// File: rtl/lin_frame_ctrl.sv
module lin_frame_ctrl
  import lin_pkg::*;
#(
  parameter int DIV_W        = 16,
  parameter int OVS_W        = 4,
  parameter int LEN_W        = 2,
  parameter int BRK_BASE     = 13,
  parameter int DELIM_BASE   = 1,
  parameter int BRK_DET_BITS = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             isMaster,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic [LEN_W-1:0] brkLen,
  input  logic [LEN_W-1:0] delimLen,
  input  logic             parityEn,
  input  logic             parityOdd,
  input  logic             txWrite,
  input  logic [7:0]       txData,
  input  logic             txBrk,
  output logic             txReady,
  output logic             txLine,
  input  logic             rxLine,
  input  logic             rxRead,
  output logic [7:0]       rxData,
  output logic             rxValid,
  output logic             parityErr,
  output logic             frameErr,
  output logic             overrunErr,
  output logic             breakDet,
  input  logic             errClear
);
  logic   tick;
  rxEvt_t rxEvt;

  lin_baud_gen #(.DIV_W(DIV_W)) i_baud (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .tick(tick));

  lin_tx_unit #(.OVS_W(OVS_W), .LEN_W(LEN_W), .BRK_BASE(BRK_BASE),
                .DELIM_BASE(DELIM_BASE)) i_tx (
    .clk(clk), .rstN(rstN), .tick(tick), .isMaster(isMaster),
    .brkLen(brkLen), .delimLen(delimLen), .parityEn(parityEn),
    .parityOdd(parityOdd), .txWrite(txWrite), .txData(txData),
    .txBrk(txBrk), .txReady(txReady), .txLine(txLine));

  lin_rx_sampler #(.OVS_W(OVS_W), .BRK_DET_BITS(BRK_DET_BITS)) i_rxs (
    .clk(clk), .rstN(rstN), .tick(tick), .rxLine(rxLine),
    .parityEn(parityEn), .parityOdd(parityOdd), .evt(rxEvt));

  lin_rx_buffer i_rxb (
    .clk(clk), .rstN(rstN), .evt(rxEvt), .isMaster(isMaster),
    .rxRead(rxRead), .errClear(errClear), .rxValid(rxValid),
    .rxData(rxData), .parityErr(parityErr), .frameErr(frameErr),
    .overrunErr(overrunErr), .breakDet(breakDet));
endmodule

// File: tb/test_lin_frame_ctrl.sv
`timescale 1ns/1ps
module test_lin_frame_ctrl;
  localparam int DIV = 1;
  localparam int BIT = 16 * (DIV + 1);
  // {parEn, parOdd, flipParity, data}
  localparam logic [10:0] VECS [6] = '{11'h055, 11'h0A3, 11'h43C, 11'h681, 11'h507, 11'h7FE};

  logic clk = 1'b0, rstN = 1'b0;
  logic isMaster = 1'b1, parityEn = 1'b0, parityOdd = 1'b0;
  logic [15:0] baudDiv = 16'(DIV);
  logic [1:0] brkLen = 2'd0, delimLen = 2'd0;
  logic txWrite = 1'b0, txBrk = 1'b0, rxLine = 1'b1, rxRead = 1'b0, errClear = 1'b0;
  logic [7:0] txData = 8'h00;
  logic txReady, txLine, rxValid, parityErr, frameErr, overrunErr, breakDet;
  logic [7:0] rxData;
  int totalCnt = 0, failCnt = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lin_frame_ctrl i_lin_frame_ctrl (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .baudDiv(baudDiv),
    .brkLen(brkLen), .delimLen(delimLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .txWrite(txWrite), .txData(txData), .txBrk(txBrk), .txReady(txReady),
    .txLine(txLine), .rxLine(rxLine), .rxRead(rxRead), .rxData(rxData),
    .rxValid(rxValid), .parityErr(parityErr), .frameErr(frameErr),
    .overrunErr(overrunErr), .breakDet(breakDet), .errClear(errClear));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  endtask

  task automatic txSend(input logic [7:0] d, input logic b);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData = d; txBrk = b; txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0; txBrk = 1'b0;
  endtask

  task automatic decodeTx(input logic withBrk, output int brkCyc, output int delimCyc,
                          output logic [7:0] d, output logic p, output logic s,
                          output int startCyc);
    brkCyc = 0; delimCyc = 0; p = 1'b0;
    @(negedge clk);
    while (txLine !== 1'b0) @(negedge clk);
    if (withBrk) begin
      while (txLine === 1'b0) begin brkCyc++; @(negedge clk); end
      while (txLine === 1'b1) begin delimCyc++; @(negedge clk); end
    end
    startCyc = cyc;
    repeat (BIT / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      d[i] = txLine;
    end
    if (parityEn) begin repeat (BIT) @(negedge clk); p = txLine; end
    repeat (BIT) @(negedge clk);
    s = txLine;
  endtask

  task automatic rxSend(input logic [7:0] d, input logic flip, input logic stopBit);
    logic pb;
    pb = (parityOdd ? ~^d : ^d) ^ flip;
    @(negedge clk);
    rxLine = 1'b0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxLine = d[i]; repeat (BIT) @(negedge clk); end
    if (parityEn) begin rxLine = pb; repeat (BIT) @(negedge clk); end
    rxLine = stopBit; repeat (BIT) @(negedge clk);
    rxLine = 1'b1;
  endtask

  task automatic pulseRead();
    @(negedge clk); rxRead = 1'b1; @(negedge clk); rxRead = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk); errClear = 1'b1; @(negedge clk); errClear = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++; totalCnt++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
    finishRun();
  end

  initial begin
    int bc, dc, s1, s2, lowRun;
    logic [7:0] d1, d2;
    logic p1, st1, p2, st2;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 txLine", txLine, 1); check("R1 txReady", txReady, 1);
    check("R1 rxValid", rxValid, 0);
    check("R1 flags", {parityErr, frameErr, overrunErr, breakDet}, 0);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] vd;
      logic vflip, expPar;
      vd = VECS[v][7:0]; vflip = VECS[v][8];
      parityOdd = VECS[v][9]; parityEn = VECS[v][10];
      expPar = parityOdd ? ~^vd : ^vd;
      fork
        txSend(vd, 1'b0);
        decodeTx(1'b0, bc, dc, d1, p1, st1, s1);
      join
      check("R2 tx data", d1, vd);
      check("R2 tx stop", st1, 1);
      if (parityEn) check("R3 tx parity", p1, expPar);
      rxSend(vd, vflip, 1'b1);
      check("R7 rxValid", rxValid, 1);
      check("R7 rxData", rxData, vd);
      check("R8 parityErr", parityErr, parityEn & vflip);
      pulseRead();
      check("R7 read clears", rxValid, 0);
      pulseClear();
      check("R12 clear", {parityErr, frameErr, overrunErr, breakDet}, 0);
    end
    parityEn = 1'b0; parityOdd = 1'b0;

    brkLen = 2'd3; delimLen = 2'd2;
    fork
      txSend(8'h55, 1'b1);
      decodeTx(1'b1, bc, dc, d1, p1, st1, s1);
    join
    check("R5 break 16", bc, 16 * BIT);
    check("R5 delim 3", dc, 3 * BIT);
    check("R5 data", d1, 8'h55);
    brkLen = 2'd0; delimLen = 2'd0;
    fork
      txSend(8'hC4, 1'b1);
      decodeTx(1'b1, bc, dc, d1, p1, st1, s1);
    join
    check("R5 break 13", bc, 13 * BIT);
    check("R5 delim 1", dc, BIT);
    check("R5 data", d1, 8'hC4);

    isMaster = 1'b0;
    fork
      txSend(8'h55, 1'b1);
      begin
        @(negedge clk);
        while (txLine !== 1'b0) @(negedge clk);
        lowRun = 0;
        while (txLine === 1'b0) begin lowRun++; @(negedge clk); end
      end
    join
    check("R6 no break in slave", lowRun, BIT);
    repeat (12 * BIT) @(negedge clk);
    isMaster = 1'b1;

    fork
      begin
        txSend(8'h12, 1'b0);
        check("R4 txReady low after write", txReady, 0);
        txSend(8'h34, 1'b0);
      end
      begin
        decodeTx(1'b0, bc, dc, d1, p1, st1, s1);
        decodeTx(1'b0, bc, dc, d2, p2, st2, s2);
      end
    join
    check("R4 first byte", d1, 8'h12);
    check("R4 second byte", d2, 8'h34);
    check("R4 back to back", s2 - s1, 10 * BIT);

    rxSend(8'h11, 1'b0, 1'b1);
    rxSend(8'h22, 1'b0, 1'b1);
    check("R10 overrunErr", overrunErr, 1);
    check("R10 keeps old byte", rxData, 8'h11);
    pulseRead(); pulseClear();

    rxSend(8'h5A, 1'b0, 1'b0);
    check("R9 frameErr", frameErr, 1);
    check("R9 data delivered", rxData, 8'h5A);
    pulseRead(); pulseClear();

    isMaster = 1'b0;
    @(negedge clk); rxLine = 1'b0;
    repeat (12 * BIT) @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    check("R11 slave breakDet", breakDet, 1);
    pulseRead(); pulseClear();
    check("R12 breakDet cleared", breakDet, 0);
    isMaster = 1'b1;
    @(negedge clk); rxLine = 1'b0;
    repeat (12 * BIT) @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    check("R11 master no breakDet", breakDet, 0);
    pulseRead(); pulseClear();

    @(negedge clk); rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    check("R14 glitch rejected", rxValid, 0);
    rxSend(8'h9D, 1'b0, 1'b1);
    check("R14 later byte", rxData, 8'h9D);
    pulseRead();

    fork
      txSend(8'hE1, 1'b0);
      decodeTx(1'b0, bc, dc, d1, p1, st1, s1);
      rxSend(8'h3B, 1'b0, 1'b1);
    join
    check("R13 tx during rx", d1, 8'hE1);
    check("R13 rx during tx", rxData, 8'h3B);
    check("R13 rx valid", rxValid, 1);

    finishRun();
  end
endmodule